// File: doc/BRIEF.md
# Time-Sliced Shared Memory Arbiter with Idle-Slot Donation

This block shares one memory port among eight processor cores. A rotating slot counter steps through the cores in fixed order. Each slot lasts two system clocks, so a full rotation takes sixteen clocks. The core that owns the current slot may use the port in the first clock of that slot. When the owning core is disabled, its slot goes to core 0. Core 0 therefore gains bandwidth whenever other cores sit idle. An enabled core always keeps its own slot. No setting is needed: who gets each slot depends only on the per-core enable vector.

An optional shortened scan limits the rotation to the slots from 0 up to a chosen highest core ID. This raises the access rate of every core in that range. A small internal memory serves the granted access. A write commits in the grant clock. Read data returns one clock later. The current slot index and its effective owner are brought out, so the grant sequence can be followed clock by clock.

Top module: `hub_slot_arbiter`

## Requirements
- R1: While reset is held and in the first clock after it is released, slot_idx is 0, owner is 0, grant is 0 and rd_valid is 0. That first clock is the grant clock of slot 0.
- R2: Every slot lasts exactly two clocks. The first clock is the grant clock and the second is the data clock. In full mode, slot_idx advances by one after every two clocks, wrapping from 7 to 0.
- R3: In a slot whose own core was enabled when the slot began, owner equals slot_idx.
- R4: In a slot whose own core was disabled when the slot began, owner is 0. owner is never any value other than slot_idx or 0.
- R5: With all eight enables set, owner equals slot_idx in every slot. Core 0 then holds only slot 0.
- R6: core_en is sampled only at the clock edge that begins a slot. A change in the middle of a slot leaves owner unchanged until the next slot.
- R7: grant is one-hot or zero. Bit i is 1 only in the grant clock, only when owner is i, and only when req[i] is 1. When the owner does not request, no bit is set, even if other cores request.
- R8: A granted access with req_we of the owner at 1 writes req_wdata of the owner to address req_addr of the owner at the end of the grant clock. A granted access with req_we at 0 sets rd_valid in the next clock, with rd_data holding the byte most recently written to that address. Without a grant, rd_valid is 0 in the next clock.
- R9: With short_scan at 1, the slot after slot s is 0 when s >= top_id, and s+1 otherwise. The rotation is therefore top_id+1 slots long. With short_scan at 0, the limit is 7.
- R10: Bit 0 of core_en has no effect: slot 0 and every donated slot belong to core 0 even when core_en[0] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| core_en | input | 8 | Per-core enable, sampled at each slot start |
| short_scan | input | 1 | 1 selects the shortened rotation |
| top_id | input | 3 | Highest slot index in the shortened rotation |
| req | input | 8 | Per-core access request |
| req_we | input | 8 | Per-core write select (1 write, 0 read) |
| req_addr | input | 32 | Per-core address, 4 bits per core, core i at bits 4i+3:4i |
| req_wdata | input | 64 | Per-core write byte, core i at bits 8i+7:8i |
| grant | output | 8 | One-hot grant in the grant clock |
| owner | output | 3 | Effective owner of the current slot |
| slot_idx | output | 3 | Current slot index |
| rd_data | output | 8 | Read data, one clock after a read grant |
| rd_valid | output | 1 | rd_data holds a fresh read result |

## Verification
The hardest case to reach is an enable change in the middle of a slot. The enable must flip after the slot edge and before the data clock, and then the owner must be seen to hold. The stimulus enables every core at a slot boundary and drops them all in the grant clock. It then confirms that the owner holds through the data clock and turns to core 0 only in the following slot. Donation is checked by sweeping all 256 enable vectors through a full rotation each. The sweep alternates between all cores requesting and only even cores requesting, so that enabled owners that do not request are also covered. Every shortened scan length is then walked through.

// File: rtl/hub_pkg.sv
package hub_pkg;
    localparam int NCORE = 8;
    localparam int IDW   = $clog2(NCORE);

    typedef logic [IDW-1:0] core_id_t;

    typedef struct packed {
        core_id_t slot;
        logic     data_clk;
        core_id_t owner;
    } slot_state_t;

    function automatic core_id_t next_slot(core_id_t cur, logic short_scan, core_id_t top);
        core_id_t last;
        last = short_scan ? top : core_id_t'(NCORE - 1);
        return (cur >= last) ? '0 : core_id_t'(cur + 1'b1);
    endfunction
endpackage

// File: rtl/hub_donate.sv
module hub_donate
    import hub_pkg::*;
(
    input  core_id_t              slot,
    input  logic [NCORE-1:0]      en,
    output core_id_t              owner
);
    logic [NCORE-1:0] keeps;

    for (genvar i = 0; i < NCORE; i++) begin : g_keep
        if (i == 0) begin : g_zero
            assign keeps[i] = 1'b1;
        end else begin : g_other
            assign keeps[i] = en[i];
        end
    end

    always_comb begin
        owner = keeps[slot] ? slot : '0;
    end
endmodule

// File: rtl/hub_slot_seq.sv
module hub_slot_seq
    import hub_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NCORE-1:0] core_en,
    input  logic             short_scan,
    input  core_id_t         top_id,
    output slot_state_t      st
);
    core_id_t upcoming;
    core_id_t upcoming_owner;

    always_comb begin
        upcoming = next_slot(st.slot, short_scan, top_id);
    end

    hub_donate u_donate (
        .slot  (upcoming),
        .en    (core_en),
        .owner (upcoming_owner)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{slot: '0, data_clk: 1'b0, owner: '0};
        end else if (st.data_clk) begin
            st.slot     <= upcoming;
            st.owner    <= upcoming_owner;
            st.data_clk <= 1'b0;
        end else begin
            st.data_clk <= 1'b1;
        end
    end
endmodule

// File: rtl/hub_mem.sv
module hub_mem #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          access,
    input  logic          write,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (access && write) begin
            store[addr] <= wdata;
        end
        if (access && !write) begin
            rdata <= store[addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
        end else begin
            rvalid <= access && !write;
        end
    end
endmodule

// File: rtl/hub_slot_arbiter.sv
module hub_slot_arbiter
    import hub_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCORE-1:0]    core_en,
    input  logic                short_scan,
    input  logic [IDW-1:0]      top_id,
    input  logic [NCORE-1:0]    req,
    input  logic [NCORE-1:0]    req_we,
    input  logic [NCORE*AW-1:0] req_addr,
    input  logic [NCORE*DW-1:0] req_wdata,
    output logic [NCORE-1:0]    grant,
    output logic [IDW-1:0]      owner,
    output logic [IDW-1:0]      slot_idx,
    output logic [DW-1:0]       rd_data,
    output logic                rd_valid
);
    slot_state_t   st;
    logic          grant_clk;
    logic          access;
    logic          sel_we;
    logic [AW-1:0] sel_addr;
    logic [DW-1:0] sel_wdata;

    hub_slot_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .core_en    (core_en),
        .short_scan (short_scan),
        .top_id     (top_id),
        .st         (st)
    );

    assign grant_clk = !st.data_clk;
    assign owner     = st.owner;
    assign slot_idx  = st.slot;

    for (genvar i = 0; i < NCORE; i++) begin : g_grant
        assign grant[i] = grant_clk && (st.owner == core_id_t'(i)) && req[i];
    end

    always_comb begin
        access    = |grant;
        sel_we    = req_we[st.owner];
        sel_addr  = req_addr[st.owner*AW +: AW];
        sel_wdata = req_wdata[st.owner*DW +: DW];
    end

    hub_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk    (clk),
        .rst    (rst),
        .access (access),
        .write  (sel_we),
        .addr   (sel_addr),
        .wdata  (sel_wdata),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );
endmodule

// File: rtl/hub_arb_chk.sv
module hub_arb_chk
    import hub_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NCORE-1:0] core_en,
    input logic             short_scan,
    input logic [IDW-1:0]   top_id,
    input logic [NCORE-1:0] req,
    input logic [NCORE-1:0] req_we,
    input logic [NCORE-1:0] grant,
    input logic [IDW-1:0]   owner,
    input logic [IDW-1:0]   slot_idx,
    input logic             rd_valid,
    input logic             grant_clk
);
    logic [NCORE-1:0] en_prev;

    always_ff @(posedge clk) begin
        en_prev <= core_en;
    end

    a_r2_slot_two_clocks: assert property (@(posedge clk) disable iff (rst)
        !$stable(slot_idx) |=> $stable(slot_idx));

    a_r2_clock_alternates: assert property (@(posedge clk) disable iff (rst)
        grant_clk |=> !grant_clk);

    a_r2_data_then_grant: assert property (@(posedge clk) disable iff (rst)
        !grant_clk |=> grant_clk);

    a_r3_keeps_own_slot: assert property (@(posedge clk) disable iff (rst)
        (!$stable(slot_idx) && en_prev[slot_idx]) |-> owner == slot_idx);

    a_r4_owner_choice: assert property (@(posedge clk) disable iff (rst)
        owner == slot_idx || owner == '0);

    a_r6_owner_held: assert property (@(posedge clk) disable iff (rst)
        !grant_clk |-> $stable(owner));

    a_r7_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r7_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

    a_r7_grant_in_first_clock: assert property (@(posedge clk) disable iff (rst)
        !grant_clk |-> grant == '0);

    a_r8_read_returns: assert property (@(posedge clk) disable iff (rst)
        ((|grant) && !req_we[owner]) |=> rd_valid);

    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !(|grant) |=> !rd_valid);

    a_r9_scan_bound: assert property (@(posedge clk) disable iff (rst)
        (short_scan && $past(short_scan) && $past(short_scan, 2) &&
         $past(top_id) == top_id && $past(top_id, 2) == top_id) |-> slot_idx <= top_id);
endmodule

bind hub_slot_arbiter hub_arb_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .core_en    (core_en),
    .short_scan (short_scan),
    .top_id     (top_id),
    .req        (req),
    .req_we     (req_we),
    .grant      (grant),
    .owner      (owner),
    .slot_idx   (slot_idx),
    .rd_valid   (rd_valid),
    .grant_clk  (grant_clk)
);

// File: tb/hub_slot_arbiter_bench.sv
module hub_slot_arbiter_bench;
    localparam int N  = 8;
    localparam int AW = 4;
    localparam int DW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    core_en = 8'h01;
    logic            short_scan = 1'b0;
    logic [2:0]      top_id = 3'd7;
    logic [N-1:0]    req = '0;
    logic [N-1:0]    req_we = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic [N*DW-1:0] req_wdata = '0;
    logic [N-1:0]    grant;
    logic [2:0]      owner;
    logic [2:0]      slot_idx;
    logic [DW-1:0]   rd_data;
    logic            rd_valid;

    int checks = 0;
    int failures = 0;
    int cur = 0;
    logic [DW-1:0] model [16];

    always #10 clk = ~clk;

    hub_slot_arbiter u_hub_slot_arbiter (
        .clk(clk), .rst(rst), .core_en(core_en), .short_scan(short_scan),
        .top_id(top_id), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .grant(grant), .owner(owner), .slot_idx(slot_idx),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int nxt(input int s, input bit ss, input int top);
        int last;
        last = ss ? top : 7;
        return (s >= last) ? 0 : s + 1;
    endfunction

    // Entered at the negedge of a data clock; leaves at the next data-clock negedge.
    task automatic step(input logic [7:0] en, input logic [7:0] rq, input logic [7:0] wev,
                        input int addr, input logic [7:0] data, input bit ss, input int top,
                        input string otag);
        int exp_slot, own;
        logic [7:0] exp_grant;
        bit rd;
        core_en    = en;
        req        = rq;
        req_we     = wev;
        req_addr   = {N{addr[3:0]}};
        req_wdata  = {N{data}};
        short_scan = ss;
        top_id     = top[2:0];
        exp_slot = nxt(cur, ss, top);
        own = (exp_slot != 0 && en[exp_slot]) ? exp_slot : 0;
        exp_grant = rq[own] ? (8'h01 << own) : 8'h00;
        rd = rq[own] && !wev[own];
        @(negedge clk);
        chk(slot_idx == exp_slot[2:0], ss ? "R9" : "R2", "slot", slot_idx, exp_slot);
        chk(owner == own[2:0], otag, "owner", owner, own);
        chk(grant == exp_grant, "R7", "grant", grant, exp_grant);
        @(negedge clk);
        chk(slot_idx == exp_slot[2:0], "R2", "slot held", slot_idx, exp_slot);
        chk(grant == 8'h00, "R7", "grant in data clock", grant, 0);
        chk(rd_valid == rd, "R8", "rd_valid", rd_valid, rd);
        if (rd) chk(rd_data == model[addr], "R8", "rd_data", rd_data, model[addr]);
        if (rq[own] && wev[own]) model[addr] = data;
        req = '0;
        cur = exp_slot;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(slot_idx == 0 && owner == 0, "R1", "slot/owner in reset", {slot_idx, owner}, 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(slot_idx == 0, "R1", "slot after reset", slot_idx, 0);
        chk(owner == 0, "R1", "owner after reset", owner, 0);
        chk(grant == 0 && rd_valid == 0, "R1", "grant/rd_valid", {grant, rd_valid}, 0);
        @(negedge clk);
        cur = 0;

        // Only core 0 enabled: core 0 holds every slot.
        for (int i = 0; i < 16; i++)
            step(8'h01, 8'h01, 8'h00, 0, 8'h00, 0, 7, "R4");

        // All enabled: plain rotation; each owner writes its address.
        for (int i = 0; i < 16; i++)
            step(8'hFF, 8'hFF, 8'hFF, i, 8'(8'h30 + i * 7), 0, 7, "R5");

        // Every enable vector across a full rotation, reads only.
        for (int e = 0; e < 256; e++) begin
            for (int s = 0; s < 8; s++) begin
                int ns;
                string t;
                ns = nxt(cur, 0, 7);
                if (ns != 0 && e[ns]) t = "R3";
                else if (!e[0]) t = "R10";
                else t = "R4";
                step(8'(e), (s % 2 == 1) ? 8'hFF : 8'h55, 8'h00, (e + s) % 16, 8'h00, 0, 7, t);
            end
        end

        // Enable dropped in mid-slot: owner holds until the next slot.
        for (int k = 0; k < 3; k++) begin
            int exp_slot;
            core_en = 8'hFF;
            req = '0;
            exp_slot = nxt(cur, 0, 7);
            @(negedge clk);
            chk(owner == exp_slot[2:0], "R3", "owner before change", owner, exp_slot);
            core_en = 8'h01;
            @(negedge clk);
            chk(owner == exp_slot[2:0], "R6", "owner after mid-slot change", owner, exp_slot);
            cur = exp_slot;
            step(8'h01, 8'h01, 8'h00, 3, 8'h00, 0, 7, "R6");
        end

        // Shortened rotation for every top_id.
        for (int t = 0; t < 8; t++) begin
            for (int s = 0; s < 2 * (t + 1) + 2; s++)
                step(8'hFF, 8'hFF, 8'h00, s % 16, 8'h00, 1, t, "R9");
        end

        // Shortened rotation with donation, then back to full mode.
        for (int s = 0; s < 8; s++)
            step(8'h05, 8'hFF, 8'h00, s, 8'h00, 1, 3, "R9");
        for (int s = 0; s < 10; s++)
            step(8'hAA, 8'hFF, 8'h00, s, 8'h00, 0, 7, "R2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule